// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences a 12-bit successive-approximation conversion. It watches three chip control inputs: a read/convert line that is active low, a chip enable that is active high and a chip select that is active low. A conversion begins when all three sit in their active state together. Whichever input arrives last triggers the start. Once running, the controller cannot be interrupted. Every new start request is ignored until the current conversion has finished.

While converting, the block holds a busy status line high. It drives a trial code to an external DAC and reads back one comparator decision per step. The trial code tests one bit per step, starting at the most significant bit. When the last bit is settled, the code is copied into a result register and a one-cycle valid pulse marks the final busy cycle.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A start is accepted only when chip_en=1, chip_sel_n=0 and rd_conv_n=0 hold together. With any one of them inactive, busy stays 0. The input that completes the combination is the trigger, whichever of the three it is.
- R2: The combined start condition must be seen at two consecutive rising clock edges, having been false at the edge before them. A condition seen at only one edge starts nothing.
- R3: busy rises in the cycle after the second qualifying edge and stays high for exactly 14 cycles: one setup cycle, 12 bit-test cycles and one hold cycle.
- R4: While busy is high, removing and reapplying the start condition neither stops nor restarts the conversion. Busy length and result are unchanged.
- R5: In the setup cycle the trial code is 0. The bit-test cycles then test bit 11 down to bit 0, one per cycle. In each of those cycles the trial code equals the bits already kept, with the bit under test set.
- R6: A tested bit is kept only when cmp_ge=1 (input at or above the trial level). The final result therefore equals the largest code that the comparator reports as at or below the input.
- R7: result_valid is high for exactly one cycle, the last busy cycle. result changes only at the edge that starts that cycle.
- R8: After reset, busy=0, result_valid=0, result=0 and trial_code=0.
- R9: A start condition held continuously through the end of a conversion does not start another one. It must first go inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_conv_n | input | 1 | Read/convert; low requests a conversion |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| cmp_ge | input | 1 | Comparator: 1 when input is at or above trial_code |
| trial_code | output | WIDTH | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | WIDTH | Last finished conversion code |
| result_valid | output | 1 | One-cycle pulse in the last busy cycle |

## Verification
Take the negative clock edge at which the third input is applied. busy must still be low at the next negative edge and must be high at the one after that. The checks sample there, then count busy cycles one negative edge at a time. The valid pulse is expected at the 14th busy sample, with result equal to the ideal code. At the 1st, 2nd and 3rd busy samples the trial codes 0, 0x800 and the second-step code are checked. A comparator model answers the trial code combinationally, so every conversion is complete and its expected value is known exactly. This makes it possible to sweep all 4096 codes.

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_conv_n,
  input  logic             chip_en,
  input  logic             chip_sel_n,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] trial_code,
  output logic             busy,
  output logic [WIDTH-1:0] result,
  output logic             result_valid
);
  localparam int IW       = $clog2(WIDTH);
  localparam int BUSY_CYC = WIDTH + 2;
  localparam int CW       = $clog2(BUSY_CYC + 2);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_CONV, S_HOLD} st_t;

  st_t             st;
  logic [WIDTH-1:0] sar;
  logic [IW-1:0]    idx;
  logic             seen1, seen2;
  logic [WIDTH-1:0] test_bit;

  wire start_cond = chip_en & ~chip_sel_n & ~rd_conv_n;
  wire start_ok   = start_cond & seen1 & ~seen2 & (st == S_IDLE);

  assign test_bit     = (st == S_CONV) ? ({{(WIDTH-1){1'b0}}, 1'b1} << idx) : '0;
  assign trial_code   = sar | test_bit;
  assign busy         = (st != S_IDLE);
  assign result_valid = (st == S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sar    <= '0;
      idx    <= '0;
      result <= '0;
      seen1  <= 1'b0;
      seen2  <= 1'b0;
    end else begin
      seen1 <= start_cond;
      seen2 <= seen1;
      case (st)
        S_IDLE: if (start_ok) begin
          st  <= S_SETUP;
          sar <= '0;
        end
        S_SETUP: begin
          st  <= S_CONV;
          idx <= IW'(WIDTH - 1);
        end
        S_CONV: begin
          if (cmp_ge) sar <= sar | test_bit;
          if (idx == '0) begin
            st     <= S_HOLD;
            result <= cmp_ge ? (sar | test_bit) : sar;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_cnt <= '0;
    else        chk_cnt <= busy ? chk_cnt + 1'b1 : '0;
  end

  a_r3_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chk_cnt < CW'(BUSY_CYC - 1)) |=> busy);
  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> chk_cnt == CW'(BUSY_CYC));
  a_r1_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_cond));
  a_r5_sar_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> trial_code == '0);
  a_r5_one_test_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(test_bit));
  a_r7_valid_last: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !busy);
  a_r7_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> result_valid);
endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_conv_n = 1'b1, chip_en = 1'b0, chip_sel_n = 1'b1;
  logic [11:0] ideal = '0;
  logic [11:0] trial_code, result;
  logic        busy, result_valid, cmp_ge;
  int          checks = 0, fails = 0;
  bit          done = 0;

  assign cmp_ge = (ideal >= trial_code);

  sar_conv_ctrl #(.WIDTH(12)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_conv_n(rd_conv_n), .chip_en(chip_en),
    .chip_sel_n(chip_sel_n), .cmp_ge(cmp_ge), .trial_code(trial_code),
    .busy(busy), .result(result), .result_valid(result_valid));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rd_conv_n = 1'b1; chip_en = 1'b0; chip_sel_n = 1'b1;
  endtask

  task automatic no_start(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, busy, 0);
    end
  endtask

  // order: 0 all together, 1 rd_conv_n last, 2 chip_en last, 3 chip_sel_n last
  task automatic do_conv(input logic [11:0] code, input int order,
                         input bit restart, input bit hold_after);
    int pre, blen, vcnt, vpos;
    logic [11:0] res, t2;
    ideal = code;
    @(negedge clk);
    if (order != 0) begin
      rd_conv_n = (order == 1); chip_en = (order != 2); chip_sel_n = (order == 3);
      no_start("R1", 3);
    end
    rd_conv_n = 1'b0; chip_en = 1'b1; chip_sel_n = 1'b0;
    pre = 0;
    do begin @(negedge clk); pre++; end while (!busy && pre < 10);
    check("R3 start latency", pre, 2);
    blen = 0; vcnt = 0; vpos = 0; res = '0;
    while (busy && blen < 40) begin
      blen++;
      if (blen == 1) check("R5 setup trial", trial_code, 0);
      if (blen == 2) check("R5 first trial", trial_code, 12'h800);
      if (blen == 3) begin
        t2 = (code >= 12'h800) ? 12'hC00 : 12'h400;
        check("R5 second trial", trial_code, t2);
      end
      if (result_valid) begin vcnt++; vpos = blen; res = result; end
      if (restart && blen == 3) idle_inputs();
      if (restart && blen == 5) begin rd_conv_n = 1'b0; chip_en = 1'b1; chip_sel_n = 1'b0; end
      @(negedge clk);
    end
    check(restart ? "R4 busy length" : "R3 busy length", blen, 14);
    check("R7 valid count", vcnt, 1);
    check("R7 valid position", vpos, 14);
    check(restart ? "R4 result" : "R6 result", res, code);
    check("R7 result held", result, code);
    if (hold_after) no_start("R9", 5);
    idle_inputs();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 busy", busy, 0);
    check("R8 valid", result_valid, 0);
    check("R8 result", result, 0);
    check("R8 trial", trial_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: one input missing blocks a start
    rd_conv_n = 1'b0; chip_en = 1'b1; chip_sel_n = 1'b1; no_start("R1 cs inactive", 4);
    idle_inputs(); @(negedge clk);
    rd_conv_n = 1'b0; chip_en = 1'b0; chip_sel_n = 1'b0; no_start("R1 ce inactive", 4);
    idle_inputs(); @(negedge clk);

    // R2: condition present at a single edge only
    rd_conv_n = 1'b0; chip_en = 1'b1; chip_sel_n = 1'b0;
    @(negedge clk); idle_inputs();
    no_start("R2", 5);

    // R1: each input as the last one
    do_conv(12'hA5C, 1, 0, 0);
    do_conv(12'h3F1, 2, 0, 0);
    do_conv(12'h800, 3, 0, 0);
    // R4 and R9
    do_conv(12'h6B2, 0, 1, 0);
    do_conv(12'hFFF, 0, 0, 1);
    do_conv(12'h000, 0, 0, 1);

    // R6: every code
    for (int c = 0; c < 4096; c++) do_conv(12'(c), 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule